// File: doc/BRIEF.md
# Multi-Port Register Array

This block is a synchronous storage array of 64 words, each 72 bits wide, that several requesters can reach in the same clock cycle. Each read port takes an enable and a 6-bit address and returns a word. Each write port takes an enable, an address and a data word. A top-level parameter picks between a narrow build with two read ports and one write port, and a wide build with four read ports and two write ports. The wide build shares one storage core between two service slots per port clock.

Every request is first captured in an input register. The storage is then read or written in the next cycle, and read results come back from an output register. A read issued in cycle N therefore shows its word in cycle N+2. A write issued in cycle N is seen by every read issued from cycle N+1 on. If both write ports aim at the same word in one cycle, the higher-numbered port decides the stored value.

A read port whose enable is low keeps its previous result. Reset clears the request and result registers, but the stored words survive it.

Top module: `mparray`

## Requirements
- R1: Every one of the 64 addresses, 0 and 63 included, stores a full 72-bit word and returns it unchanged on any read port.
- R2: With DOUBLE_RATE=1 the block has four read ports and two write ports; with DOUBLE_RATE=0 it has two and one. Port k uses bits [k*6 +: 6] of an address bus and bits [k*72 +: 72] of a data bus.
- R3: A read whose enable is high in cycle N drives its word on that port's data output from cycle N+2. All read ports have the same latency.
- R4: A write whose enable is high in cycle N is returned by a read of that address issued in cycle N+1 or later.
- R5: When both write ports are enabled for the same address in the same cycle, the data from write port 1 is stored.
- R6: A read port whose enable is low keeps its data output at the last value it returned.
- R7: Reset is synchronous and active high. It drives every read data output to zero, and any request presented while it is high has no effect.
- R8: Reset does not alter the stored words; data written before reset reads back unchanged after it.
- R9: A write port whose enable is low changes no stored word, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | NRD | Read request enable, one bit per read port |
| rd_addr | input | NRD*6 | Read addresses, packed by port |
| wr_en | input | NWR | Write enable, one bit per write port |
| wr_addr | input | NWR*6 | Write addresses, packed by port |
| wr_data | input | NWR*72 | Write data, packed by port |
| rd_data | output | NRD*72 | Registered read data, packed by port |

## Verification
A wrong winner between the write ports, or a lost write, stays hidden until that address is read again. It then shows as a wrong word two cycles after that read is issued. A read register that loads while its enable is low shows up one cycle later as a change on an idle port. A result register that is off by a cycle shows up on the first read after reset, since every result is compared in exactly its third cycle. A reset that clears the stored words only shows on the readback that follows the reset.

// File: rtl/mparray_pkg.sv
package mparray_pkg;

  // Number of read ports for a given rate selection.
  function automatic int rd_ports(bit double_rate);
    return double_rate ? 4 : 2;
  endfunction

  // Number of write ports for a given rate selection.
  function automatic int wr_ports(bit double_rate);
    return double_rate ? 2 : 1;
  endfunction

  // Address width needed to reach every word.
  function automatic int addr_bits(int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/mparray_inreg.sv
module mparray_inreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/mparray_store.sv
module mparray_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 72,
  parameter int AW    = 6,
  parameter int NRD   = 4,
  parameter int NWR   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NWR-1:0]       wq_en,
  input  logic [NWR*AW-1:0]    wq_addr,
  input  logic [NWR*WIDTH-1:0] wq_data,
  input  logic [NRD*AW-1:0]    rq_addr,
  output logic [NRD*WIDTH-1:0] rarr,
  output logic [NWR-1:0]       wr_commit
);

  logic [WIDTH-1:0] mem [DEPTH];

  // A write port commits unless a later-numbered enabled port hits the same word.
  function automatic logic port_wins(int i, logic [NWR-1:0] en, logic [NWR*AW-1:0] ad);
    logic w;
    w = en[i];
    for (int k = i + 1; k < NWR; k++) begin
      if (en[k] && (ad[k*AW +: AW] == ad[i*AW +: AW])) w = 1'b0;
    end
    return w;
  endfunction

  for (genvar i = 0; i < NWR; i++) begin : g_win
    assign wr_commit[i] = port_wins(i, wq_en, wq_addr);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NWR; i++) begin
      if (wr_commit[i]) mem[wq_addr[i*AW +: AW]] <= wq_data[i*WIDTH +: WIDTH];
    end
  end

  for (genvar j = 0; j < NRD; j++) begin : g_rd
    assign rarr[j*WIDTH +: WIDTH] = mem[rq_addr[j*AW +: AW]];
  end

  for (genvar i = 0; i < NWR; i++) begin : g_wchk
    // R4
    wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
      wr_commit[i] |=> mem[$past(wq_addr[i*AW +: AW])] == $past(wq_data[i*WIDTH +: WIDTH]));
  end

  if (NWR > 1) begin : g_coll
    // R5
    collision_chk: assert property (@(posedge clk) disable iff (rst)
      (wq_en[0] && wq_en[NWR-1] && (wq_addr[0 +: AW] == wq_addr[(NWR-1)*AW +: AW]))
      |=> mem[$past(wq_addr[(NWR-1)*AW +: AW])] == $past(wq_data[(NWR-1)*WIDTH +: WIDTH]));
  end

endmodule

// File: rtl/mparray_rdout.sv
module mparray_rdout #(
  parameter int WIDTH = 72
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_q,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (en_q) q <= word;
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> $stable(q));

  // R7
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> q == '0);

endmodule

// File: rtl/mparray.sv
module mparray
  import mparray_pkg::*;
#(
  parameter bit DOUBLE_RATE = 1'b1,
  parameter int DEPTH       = 64,
  parameter int WIDTH       = 72,
  localparam int NRD        = rd_ports(DOUBLE_RATE),
  localparam int NWR        = wr_ports(DOUBLE_RATE),
  localparam int AW         = addr_bits(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NRD-1:0]       rd_en,
  input  logic [NRD*AW-1:0]    rd_addr,
  input  logic [NWR-1:0]       wr_en,
  input  logic [NWR*AW-1:0]    wr_addr,
  input  logic [NWR*WIDTH-1:0] wr_data,
  output logic [NRD*WIDTH-1:0] rd_data
);

  logic [NRD-1:0]       rq_en;
  logic [NRD*AW-1:0]    rq_addr;
  logic [NWR-1:0]       wq_en;
  logic [NWR*AW-1:0]    wq_addr;
  logic [NWR*WIDTH-1:0] wq_data;
  logic [NRD*WIDTH-1:0] rarr;
  logic [NWR-1:0]       wr_commit;

  for (genvar j = 0; j < NRD; j++) begin : g_rin
    logic [AW:0] bus;
    mparray_inreg #(.W(AW + 1)) u_reg (
      .clk (clk),
      .rst (rst),
      .d   ({rd_en[j], rd_addr[j*AW +: AW]}),
      .q   (bus)
    );
    assign rq_en[j]            = bus[AW];
    assign rq_addr[j*AW +: AW] = bus[AW-1:0];
  end

  for (genvar i = 0; i < NWR; i++) begin : g_win
    logic [WIDTH+AW:0] bus;
    mparray_inreg #(.W(WIDTH + AW + 1)) u_reg (
      .clk (clk),
      .rst (rst),
      .d   ({wr_en[i], wr_addr[i*AW +: AW], wr_data[i*WIDTH +: WIDTH]}),
      .q   (bus)
    );
    assign wq_en[i]                  = bus[WIDTH+AW];
    assign wq_addr[i*AW +: AW]       = bus[WIDTH +: AW];
    assign wq_data[i*WIDTH +: WIDTH] = bus[WIDTH-1:0];
  end

  mparray_store #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH),
    .AW    (AW),
    .NRD   (NRD),
    .NWR   (NWR)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .wq_en     (wq_en),
    .wq_addr   (wq_addr),
    .wq_data   (wq_data),
    .rq_addr   (rq_addr),
    .rarr      (rarr),
    .wr_commit (wr_commit)
  );

  for (genvar j = 0; j < NRD; j++) begin : g_rout
    mparray_rdout #(.WIDTH(WIDTH)) u_out (
      .clk  (clk),
      .rst  (rst),
      .en_q (rq_en[j]),
      .word (rarr[j*WIDTH +: WIDTH]),
      .q    (rd_data[j*WIDTH +: WIDTH])
    );
  end

  // R7
  req_flush_chk: assert property (@(posedge clk)
    rst |=> (rq_en == '0) && (wq_en == '0));

endmodule

// File: tb/mparray_tb.sv
module mparray_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int W     = 72;
  localparam int AW    = 6;
  localparam int NRD   = 4;
  localparam int NWR   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NRD-1:0]    rd_en   = '0;
  logic [NRD*AW-1:0] rd_addr = '0;
  logic [NWR-1:0]    wr_en   = '0;
  logic [NWR*AW-1:0] wr_addr = '0;
  logic [NWR*W-1:0]  wr_data = '0;
  logic [NRD*W-1:0]  rd_data;

  mparray u_dut (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    int          port;
    int          tag;
    logic [W-1:0] exp;
  } item_t;

  item_t sbq[$];
  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  logic [W-1:0] model [DEPTH];
  logic [W-1:0] lastexp [NRD];
  bit           lastvalid [NRD];

  bit           s_ren [NRD];
  int           s_ra  [NRD];
  bit           s_wen [NWR];
  int           s_wa  [NWR];
  logic [W-1:0] s_wd  [NWR];
  int           cur_tag = 1;
  logic [31:0]  rng = 32'h1234_5678;

  function automatic logic [W-1:0] pat(int a);
    logic [7:0] b;
    b = 8'(a);
    return {b, {8{b ^ 8'h5A}}};
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic clear_stage();
    for (int p = 0; p < NRD; p++) begin s_ren[p] = 1'b0; s_ra[p] = 0; end
    for (int w = 0; w < NWR; w++) begin s_wen[w] = 1'b0; s_wa[w] = 0; s_wd[w] = '0; end
  endtask

  // Driver: one port-clock cycle of requests, expectations pushed to the scoreboard.
  task automatic step();
    item_t it;
    @(negedge clk);
    for (int p = 0; p < NRD; p++) begin
      rd_en[p] = s_ren[p];
      rd_addr[p*AW +: AW] = AW'(s_ra[p]);
    end
    for (int w = 0; w < NWR; w++) begin
      wr_en[w] = s_wen[w];
      wr_addr[w*AW +: AW] = AW'(s_wa[w]);
      wr_data[w*W +: W] = s_wd[w];
    end
    for (int p = 0; p < NRD; p++) begin
      it.due = cyc + 2;
      it.port = p;
      if (s_ren[p]) begin
        it.tag = cur_tag;
        it.exp = model[s_ra[p]];
        lastexp[p] = it.exp;
        lastvalid[p] = 1'b1;
        sbq.push_back(it);
      end else if (lastvalid[p]) begin
        it.tag = 6; // R6 hold on idle port
        it.exp = lastexp[p];
        sbq.push_back(it);
      end
    end
    // Port 1 applied last: it wins a same-address collision (R5)
    for (int w = 0; w < NWR; w++) if (s_wen[w]) model[s_wa[w]] = s_wd[w];
    clear_stage();
  endtask

  // Monitor: compare each expectation in the cycle it falls due.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      logic [W-1:0] act;
      it = sbq.pop_front();
      act = rd_data[it.port*W +: W];
      tests_run++;
      if (it.due != cyc || act !== it.exp) begin
        tests_failed++;
        $display("FAIL R%0d port %0d cycle %0d: actual %h expected %h",
                 it.tag, it.port, cyc, act, it.exp);
      end
    end
  end

  task automatic check_zero_outputs();
    tests_run++;
    if (rd_data !== '0) begin
      tests_failed++;
      $display("FAIL R7 outputs after reset: actual %h expected 0", rd_data);
    end
  endtask

  task automatic quiet(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    clear_stage();
    for (int p = 0; p < NRD; p++) begin lastexp[p] = '0; lastvalid[p] = 1'b0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check_zero_outputs(); // R7 reset state
    for (int p = 0; p < NRD; p++) begin lastexp[p] = '0; lastvalid[p] = 1'b1; end

    // R2: fill all words, two writes per cycle
    for (int k = 0; k < DEPTH / 2; k++) begin
      s_wen[0] = 1'b1; s_wa[0] = 2 * k;     s_wd[0] = pat(2 * k);
      s_wen[1] = 1'b1; s_wa[1] = 2 * k + 1; s_wd[1] = pat(2 * k + 1);
      step();
    end
    // R2: read back through all four ports
    cur_tag = 2;
    for (int k = 0; k < DEPTH / 4; k++) begin
      for (int p = 0; p < NRD; p++) begin s_ren[p] = 1'b1; s_ra[p] = 4 * k + ((p + k) % 4); end
      step();
    end
    // R1: boundary addresses on every port
    cur_tag = 1;
    for (int p = 0; p < NRD; p++) begin s_ren[p] = 1'b1; s_ra[p] = (p % 2) ? 63 : 0; end
    step();
    quiet(3); // R6 holds on all ports

    // R5: both write ports on address 5
    s_wen[0] = 1'b1; s_wa[0] = 5; s_wd[0] = {8'hAA, 64'h0123_4567_89AB_CDEF};
    s_wen[1] = 1'b1; s_wa[1] = 5; s_wd[1] = {8'h55, 64'hFEDC_BA98_7654_3210};
    step();
    cur_tag = 5;
    s_ren[0] = 1'b1; s_ra[0] = 5; s_ren[2] = 1'b1; s_ra[2] = 5;
    step();

    // R4: write in N, read in N+1 on a late-slot port
    s_wen[0] = 1'b1; s_wa[0] = 9; s_wd[0] = {8'h3C, 64'hDEAD_BEEF_0000_1111};
    step();
    cur_tag = 4;
    s_ren[3] = 1'b1; s_ra[3] = 9; s_ren[1] = 1'b1; s_ra[1] = 9;
    step();

    // R9: disabled write with live address/data changes nothing
    s_wen[0] = 1'b0; s_wa[0] = 12; s_wd[0] = {W{1'b1}};
    s_wen[1] = 1'b0; s_wa[1] = 13; s_wd[1] = {W{1'b1}};
    step();
    cur_tag = 9;
    s_ren[0] = 1'b1; s_ra[0] = 12; s_ren[3] = 1'b1; s_ra[3] = 13;
    step();
    quiet(2);

    // R3: mixed random traffic, latency checked on every read
    cur_tag = 3;
    for (int k = 0; k < 400; k++) begin
      for (int w = 0; w < NWR; w++) begin
        rng = nxt(rng);
        s_wen[w] = rng[0];
        s_wa[w]  = int'(rng[7:2]);
        s_wd[w]  = {rng[31:24], rng, nxt(rng)};
      end
      for (int p = 0; p < NRD; p++) begin
        rng = nxt(rng);
        s_ren[p] = rng[1];
        s_ra[p]  = int'(rng[13:8]);
        while ((s_wen[0] && s_ra[p] == s_wa[0]) || (s_wen[1] && s_ra[p] == s_wa[1]))
          s_ra[p] = (s_ra[p] + 1) % DEPTH;
      end
      step();
    end

    // Drain, then reset in mid-run (R7, R8)
    for (int p = 0; p < NRD; p++) lastvalid[p] = 1'b0;
    quiet(3);
    @(negedge clk);
    rst = 1'b1;
    wr_en = 2'b11;
    wr_addr = {6'd21, 6'd20};
    wr_data = {W{2'b10}};
    rd_en = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wr_en = '0;
    rd_en = '0;
    check_zero_outputs(); // R7 outputs cleared
    for (int p = 0; p < NRD; p++) begin lastexp[p] = '0; lastvalid[p] = 1'b1; end
    cur_tag = 8;
    s_ren[0] = 1'b1; s_ra[0] = 20; s_ren[1] = 1'b1; s_ra[1] = 21;
    s_ren[2] = 1'b1; s_ra[2] = 5;  s_ren[3] = 1'b1; s_ra[3] = 63;
    step();
    quiet(4);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule